// File: doc/BRIEF.md
# DMA Fault Check and Status Capture

This block watches a multi-channel DMA engine for configuration and bus faults. When the engine presents a channel for service, it checks that channel's descriptor and the priority tables. Source and destination addresses and offsets must be aligned to their transfer sizes. Group priorities must be distinct, and so must the channel priorities inside each group. Bus error strobes from the source and destination sides are accepted on any cycle. An external cancel strobe marks the active transfer as cancelled; it is not treated as a fault.

Any fault raises a halt request in the same cycle. It sets the failing channel's bit in a per-channel error bitmap and overwrites a packed status word with the cause and, for most causes, the channel number. The block drives no completion or interrupt signals. Software clears bitmap bits one at a time through a clear port.

Top module: `dma_fault_capture`

## Requirements
- R1: A fault raises `halt_o` combinationally in the cycle it is presented. At the next clock edge it sets bit `act_ch_i` of `err_map_o`. A cancel also raises `halt_o`, but it sets no bitmap bit.
- R2: `valid_o` and `status_o[31]` both equal the OR of all `err_map_o` bits. They reflect the bitmap as it stands after each clock edge.
- R3: When `chk_valid_i` is high, the size code is checked against the address and the offset on each side. Size 0 (byte) checks nothing. Size 1 (halfword) requires bit 0 to be zero. Sizes 2 and 3 (word) require bits [1:0] to be zero. The flags are: source address `status_o[7]`, source offset `status_o[6]`, destination address `status_o[5]`, destination offset `status_o[4]`.
- R4: When `chk_valid_i` is high and two entries of `grp_pri_i` are equal, a group priority fault `status_o[15]` is recorded. Group g occupies bits [2g+1:2g].
- R5: When `chk_valid_i` is high and two channel priorities in the same group are equal, a channel priority fault `status_o[14]` is recorded. Channel c occupies `ch_pri_i` bits [4c+3:4c], and group g holds channels 16g to 16g+15.
- R6: `status_o[13:8]` takes the channel of each recorded event. Group and channel priority faults are the exception and leave this field unchanged.
- R7: A cancel (`cancel_i` with no fault that cycle) sets `status_o[16]` and records the channel.
- R8: At most one cause is recorded per cycle, chosen in this order: source bus error `status_o[1]`, destination bus error `status_o[0]`, group priority, channel priority, source address, source offset, destination address, destination offset, cancel. The new event clears all earlier cause flags. `status_o[3:2]` and `status_o[30:17]` read zero.
- R9: A pulse on `clr_en_i` clears bitmap bit `clr_ch_i` at the next edge. If the same channel faults in that cycle, the fault wins.
- R10: Reset clears the bitmap and the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_valid_i | input | 1 | Descriptor and priorities presented for check |
| act_ch_i | input | 6 | Active channel number |
| saddr_i | input | 32 | Source address |
| daddr_i | input | 32 | Destination address |
| soff_i | input | 16 | Source offset |
| doff_i | input | 16 | Destination offset |
| ssize_i | input | 2 | Source size code |
| dsize_i | input | 2 | Destination size code |
| grp_pri_i | input | 8 | Group priority table |
| ch_pri_i | input | 256 | Channel priority table |
| cancel_i | input | 1 | External cancel strobe |
| sbe_i | input | 1 | Source bus error |
| dbe_i | input | 1 | Destination bus error |
| clr_en_i | input | 1 | Clear strobe |
| clr_ch_i | input | 6 | Channel to clear |
| halt_o | output | 1 | Halt request to engine |
| err_map_o | output | 64 | Per-channel error bitmap |
| status_o | output | 32 | Packed error status word |
| valid_o | output | 1 | Any error bit set |

## Verification
`halt_o` is combinational. The bench drives each vector just after a falling edge and compares `halt_o` one nanosecond later, before the rising edge. The bitmap, status word and valid flag are registered once, so they are due one cycle after the vector. The bench checks them at the following falling edge against a model that it updates at the same point. Random vectors mix aligned and misaligned descriptors, duplicate priority entries, bus errors, cancels and clears. Directed vectors cover each cause, the cause ordering, and a clear that collides with a fault on the same channel.

// File: rtl/dma_fault_pkg.sv
`timescale 1ns/1ps
package dma_fault_pkg;
  typedef enum logic [3:0] {
    CAUSE_NONE, CAUSE_SBE, CAUSE_DBE, CAUSE_GPE, CAUSE_CPE,
    CAUSE_SAE, CAUSE_SOE, CAUSE_DAE, CAUSE_DOE, CAUSE_CANCEL
  } cause_e;

  // status word flag positions (little-endian numbering)
  localparam int unsigned ST_DBE = 0;
  localparam int unsigned ST_SBE = 1;
  localparam int unsigned ST_DOE = 4;
  localparam int unsigned ST_DAE = 5;
  localparam int unsigned ST_SOE = 6;
  localparam int unsigned ST_SAE = 7;

  function automatic logic misaligned(input logic [1:0] size, input logic [1:0] low);
    case (size)
      2'd0:    return 1'b0;
      2'd1:    return low[0];
      default: return |low;
    endcase
  endfunction
endpackage

// File: rtl/dma_desc_check.sv
`timescale 1ns/1ps
module dma_desc_check #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] saddr_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic [OFF_W-1:0]  soff_i,
  input  logic [OFF_W-1:0]  doff_i,
  input  logic [1:0]        ssize_i,
  input  logic [1:0]        dsize_i,
  output logic              sae_o,
  output logic              soe_o,
  output logic              dae_o,
  output logic              doe_o
);
  import dma_fault_pkg::*;

  logic [ADDR_W-3:0] unused_addr;
  logic [OFF_W-3:0]  unused_off;

  always_comb begin
    sae_o = misaligned(ssize_i, saddr_i[1:0]);
    soe_o = misaligned(ssize_i, soff_i[1:0]);
    dae_o = misaligned(dsize_i, daddr_i[1:0]);
    doe_o = misaligned(dsize_i, doff_i[1:0]);
    unused_addr = saddr_i[ADDR_W-1:2] ^ daddr_i[ADDR_W-1:2];
    unused_off  = soff_i[OFF_W-1:2] ^ doff_i[OFF_W-1:2];
  end
endmodule

// File: rtl/dma_pri_check.sv
`timescale 1ns/1ps
module dma_pri_check #(
  parameter int unsigned NUM_GROUPS   = 4,
  parameter int unsigned CH_PER_GROUP = 16,
  parameter int unsigned GPRI_W       = 2,
  parameter int unsigned CPRI_W       = 4,
  localparam int unsigned NUM_CH      = NUM_GROUPS * CH_PER_GROUP
) (
  input  logic [NUM_GROUPS*GPRI_W-1:0] grp_pri_i,
  input  logic [NUM_CH*CPRI_W-1:0]     ch_pri_i,
  output logic                         gpe_o,
  output logic                         cpe_o
);
  logic [NUM_GROUPS-1:0] grp_dup;

  always_comb begin
    gpe_o = 1'b0;
    for (int i = 0; i < NUM_GROUPS; i++)
      for (int j = i + 1; j < NUM_GROUPS; j++)
        if (grp_pri_i[i*GPRI_W +: GPRI_W] == grp_pri_i[j*GPRI_W +: GPRI_W]) gpe_o = 1'b1;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int unsigned BASE = g * CH_PER_GROUP;
    always_comb begin
      grp_dup[g] = 1'b0;
      for (int i = 0; i < CH_PER_GROUP; i++)
        for (int j = i + 1; j < CH_PER_GROUP; j++)
          if (ch_pri_i[(BASE+i)*CPRI_W +: CPRI_W] == ch_pri_i[(BASE+j)*CPRI_W +: CPRI_W])
            grp_dup[g] = 1'b1;
    end
  end

  assign cpe_o = |grp_dup;
endmodule

// File: rtl/dma_fault_record.sv
`timescale 1ns/1ps
module dma_fault_record #(
  parameter int unsigned NUM_CH = 64,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  dma_fault_pkg::cause_e   cause_i,
  input  logic [CH_W-1:0]         ch_i,
  input  logic                    clr_en_i,
  input  logic [CH_W-1:0]         clr_ch_i,
  output logic                    rec_err_o,
  output logic [NUM_CH-1:0]       map_o,
  output logic                    ecx_o,
  output logic                    gpe_o,
  output logic                    cpe_o,
  output logic [CH_W-1:0]         ch_o,
  output logic [7:0]              flags_o
);
  import dma_fault_pkg::*;

  logic [NUM_CH-1:0] map_d;
  logic [7:0]        flags_d;

  assign rec_err_o = (cause_i != CAUSE_NONE) && (cause_i != CAUSE_CANCEL);

  always_comb begin
    map_d = map_o;
    if (clr_en_i) map_d[clr_ch_i] = 1'b0;
    if (rec_err_o) map_d[ch_i] = 1'b1;  // set wins over clear
    flags_d = '0;
    case (cause_i)
      CAUSE_SBE: flags_d[ST_SBE] = 1'b1;
      CAUSE_DBE: flags_d[ST_DBE] = 1'b1;
      CAUSE_SAE: flags_d[ST_SAE] = 1'b1;
      CAUSE_SOE: flags_d[ST_SOE] = 1'b1;
      CAUSE_DAE: flags_d[ST_DAE] = 1'b1;
      CAUSE_DOE: flags_d[ST_DOE] = 1'b1;
      default:   flags_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_o   <= '0;
      ecx_o   <= 1'b0;
      gpe_o   <= 1'b0;
      cpe_o   <= 1'b0;
      ch_o    <= '0;
      flags_o <= '0;
    end else begin
      map_o <= map_d;
      if (cause_i != CAUSE_NONE) begin
        ecx_o   <= (cause_i == CAUSE_CANCEL);
        gpe_o   <= (cause_i == CAUSE_GPE);
        cpe_o   <= (cause_i == CAUSE_CPE);
        flags_o <= flags_d;
        if (cause_i != CAUSE_GPE && cause_i != CAUSE_CPE) ch_o <= ch_i;
      end
    end
  end
endmodule

// File: rtl/dma_fault_capture.sv
`timescale 1ns/1ps
module dma_fault_capture #(
  parameter int unsigned NUM_GROUPS   = 4,
  parameter int unsigned CH_PER_GROUP = 16,
  parameter int unsigned GPRI_W       = 2,
  parameter int unsigned CPRI_W       = 4,
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned OFF_W        = 16,
  localparam int unsigned NUM_CH      = NUM_GROUPS * CH_PER_GROUP,
  localparam int unsigned CH_W        = $clog2(NUM_CH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         chk_valid_i,
  input  logic [CH_W-1:0]              act_ch_i,
  input  logic [ADDR_W-1:0]            saddr_i,
  input  logic [ADDR_W-1:0]            daddr_i,
  input  logic [OFF_W-1:0]             soff_i,
  input  logic [OFF_W-1:0]             doff_i,
  input  logic [1:0]                   ssize_i,
  input  logic [1:0]                   dsize_i,
  input  logic [NUM_GROUPS*GPRI_W-1:0] grp_pri_i,
  input  logic [NUM_CH*CPRI_W-1:0]     ch_pri_i,
  input  logic                         cancel_i,
  input  logic                         sbe_i,
  input  logic                         dbe_i,
  input  logic                         clr_en_i,
  input  logic [CH_W-1:0]              clr_ch_i,
  output logic                         halt_o,
  output logic [NUM_CH-1:0]            err_map_o,
  output logic [31:0]                  status_o,
  output logic                         valid_o
);
  import dma_fault_pkg::*;

  logic gpe_w, cpe_w, sae_w, soe_w, dae_w, doe_w, rec_err_w;
  logic ecx_q, gpe_q, cpe_q;
  logic [CH_W-1:0] ch_q;
  logic [7:0] flags_q;
  cause_e cause;

  dma_desc_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_desc (
    .saddr_i(saddr_i), .daddr_i(daddr_i), .soff_i(soff_i), .doff_i(doff_i),
    .ssize_i(ssize_i), .dsize_i(dsize_i),
    .sae_o(sae_w), .soe_o(soe_w), .dae_o(dae_w), .doe_o(doe_w)
  );

  dma_pri_check #(
    .NUM_GROUPS(NUM_GROUPS), .CH_PER_GROUP(CH_PER_GROUP),
    .GPRI_W(GPRI_W), .CPRI_W(CPRI_W)
  ) u_pri (
    .grp_pri_i(grp_pri_i), .ch_pri_i(ch_pri_i), .gpe_o(gpe_w), .cpe_o(cpe_w)
  );

  always_comb begin
    cause = CAUSE_NONE;
    if      (sbe_i)                 cause = CAUSE_SBE;
    else if (dbe_i)                 cause = CAUSE_DBE;
    else if (chk_valid_i && gpe_w)  cause = CAUSE_GPE;
    else if (chk_valid_i && cpe_w)  cause = CAUSE_CPE;
    else if (chk_valid_i && sae_w)  cause = CAUSE_SAE;
    else if (chk_valid_i && soe_w)  cause = CAUSE_SOE;
    else if (chk_valid_i && dae_w)  cause = CAUSE_DAE;
    else if (chk_valid_i && doe_w)  cause = CAUSE_DOE;
    else if (cancel_i)              cause = CAUSE_CANCEL;
  end

  assign halt_o = (cause != CAUSE_NONE);

  dma_fault_record #(.NUM_CH(NUM_CH)) u_rec (
    .clk_i(clk_i), .rst_ni(rst_ni), .cause_i(cause), .ch_i(act_ch_i),
    .clr_en_i(clr_en_i), .clr_ch_i(clr_ch_i), .rec_err_o(rec_err_w),
    .map_o(err_map_o), .ecx_o(ecx_q), .gpe_o(gpe_q), .cpe_o(cpe_q),
    .ch_o(ch_q), .flags_o(flags_q)
  );

  assign valid_o = |err_map_o;

  always_comb begin
    status_o        = '0;
    status_o[31]    = valid_o;
    status_o[16]    = ecx_q;
    status_o[15]    = gpe_q;
    status_o[14]    = cpe_q;
    status_o[13:8]  = 6'(ch_q);
    status_o[7:0]   = flags_q;
  end
endmodule

// File: rtl/dma_fault_capture_chk.sv
`timescale 1ns/1ps
module dma_fault_capture_chk #(
  parameter int unsigned NUM_CH = 64,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halt_o,
  input logic [CH_W-1:0]   act_ch_i,
  input logic [NUM_CH-1:0] err_map_o,
  input logic              valid_o,
  input logic [31:0]       status_o,
  input logic              clr_en_i,
  input logic [CH_W-1:0]   clr_ch_i,
  input logic              chk_valid_i,
  input logic              sbe_i,
  input logic              dbe_i,
  input logic              gpe_w,
  input logic              cpe_w,
  input logic              rec_err_w
);
  p_halt_on_fault_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_err_w |-> halt_o);

  p_map_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_err_w |=> (err_map_o[$past(act_ch_i)] == 1'b1));

  p_valid_or_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o == status_o[31]) && (valid_o == (err_map_o != '0)));

  p_prio_keeps_ch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && !sbe_i && !dbe_i && (gpe_w || cpe_w)) |=> $stable(status_o[13:8]));

  p_single_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({status_o[16:14], status_o[7:0]}) && (status_o[3:2] == 2'b00));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !(rec_err_w && clr_ch_i == act_ch_i)) |=> (err_map_o[$past(clr_ch_i)] == 1'b0));
endmodule

bind dma_fault_capture dma_fault_capture_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .halt_o(halt_o), .act_ch_i(act_ch_i),
  .err_map_o(err_map_o), .valid_o(valid_o), .status_o(status_o),
  .clr_en_i(clr_en_i), .clr_ch_i(clr_ch_i), .chk_valid_i(chk_valid_i),
  .sbe_i(sbe_i), .dbe_i(dbe_i), .gpe_w(gpe_w), .cpe_w(cpe_w), .rec_err_w(rec_err_w)
);

// File: tb/dma_fault_capture_bench.sv
`timescale 1ns/1ps
module dma_fault_capture_bench;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic chk_valid, cancel, sbe, dbe, clr_en;
  logic [5:0] act_ch, clr_ch;
  logic [31:0] saddr, daddr;
  logic [15:0] soff, doff;
  logic [1:0] ssize, dsize;
  logic [7:0] grp_pri;
  logic [255:0] ch_pri;
  logic halt, valid;
  logic [63:0] err_map;
  logic [31:0] status;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [63:0] m_map;
  logic m_ecx, m_gpe, m_cpe;
  logic [5:0] m_ch;
  logic [7:0] m_flags;

  always #4 clk = ~clk;

  dma_fault_capture u_dma_fault_capture (
    .clk_i(clk), .rst_ni(rst_ni), .chk_valid_i(chk_valid), .act_ch_i(act_ch),
    .saddr_i(saddr), .daddr_i(daddr), .soff_i(soff), .doff_i(doff),
    .ssize_i(ssize), .dsize_i(dsize), .grp_pri_i(grp_pri), .ch_pri_i(ch_pri),
    .cancel_i(cancel), .sbe_i(sbe), .dbe_i(dbe), .clr_en_i(clr_en), .clr_ch_i(clr_ch),
    .halt_o(halt), .err_map_o(err_map), .status_o(status), .valid_o(valid)
  );

  function automatic bit mis(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 2'd0) return 0;
    if (sz == 2'd1) return lo[0];
    return lo != 2'b00;
  endfunction

  function automatic bit gdup(input logic [7:0] g);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        if (i != j && g[i*2 +: 2] == g[j*2 +: 2]) return 1;
    return 0;
  endfunction

  function automatic bit cdup(input logic [255:0] c);
    for (int g = 0; g < 4; g++)
      for (int i = 0; i < 16; i++)
        for (int j = i + 1; j < 16; j++)
          if (c[(g*16+i)*4 +: 4] == c[(g*16+j)*4 +: 4]) return 1;
    return 0;
  endfunction

  // 0 none,1 sbe,2 dbe,3 gpe,4 cpe,5 sae,6 soe,7 dae,8 doe,9 cancel
  function automatic int exp_cause();
    if (sbe) return 1;
    if (dbe) return 2;
    if (chk_valid && gdup(grp_pri)) return 3;
    if (chk_valid && cdup(ch_pri)) return 4;
    if (chk_valid && mis(ssize, saddr[1:0])) return 5;
    if (chk_valid && mis(ssize, soff[1:0])) return 6;
    if (chk_valid && mis(dsize, daddr[1:0])) return 7;
    if (chk_valid && mis(dsize, doff[1:0])) return 8;
    if (cancel) return 9;
    return 0;
  endfunction

  function automatic logic [31:0] exp_status();
    return {(m_map != 64'd0), 14'd0, m_ecx, m_gpe, m_cpe, m_ch, m_flags};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clean();
    chk_valid = 0; cancel = 0; sbe = 0; dbe = 0; clr_en = 0; clr_ch = 0; act_ch = 0;
    saddr = 32'h1000; daddr = 32'h2000; soff = 16'd4; doff = 16'd4; ssize = 2; dsize = 2;
    grp_pri = {2'd3, 2'd2, 2'd1, 2'd0};
    for (int c = 0; c < 64; c++) ch_pri[c*4 +: 4] = 4'(c % 16);
  endtask

  // inputs already driven after a negedge; check halt, advance one cycle, check state
  task automatic step(input string req);
    int c;
    #1;
    c = exp_cause();
    check({req, " halt R1"}, {63'd0, halt}, {63'd0, c != 0});
    if (c >= 1 && c <= 8) m_map[act_ch] = 1'b1;
    if (clr_en && !(c >= 1 && c <= 8 && clr_ch == act_ch)) m_map[clr_ch] = 1'b0;
    if (c != 0) begin
      m_ecx = (c == 9); m_gpe = (c == 3); m_cpe = (c == 4); m_flags = 8'd0;
      case (c)
        1: m_flags[1] = 1; 2: m_flags[0] = 1; 5: m_flags[7] = 1;
        6: m_flags[6] = 1; 7: m_flags[5] = 1; 8: m_flags[4] = 1;
        default: ;
      endcase
      if (c != 3 && c != 4) m_ch = act_ch;
    end
    @(negedge clk);
    check({req, " map R1 R9"}, err_map, m_map);
    check({req, " status R3-8"}, {32'd0, status}, {32'd0, exp_status()});
    check({req, " valid R2"}, {63'd0, valid}, {63'd0, m_map != 64'd0});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hang expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    m_map = 0; m_ecx = 0; m_gpe = 0; m_cpe = 0; m_ch = 0; m_flags = 0;
    clean();
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 map", err_map, 64'd0);
    check("R10 status", {32'd0, status}, 64'd0);
    rst_ni = 1;
    @(negedge clk);

    // R3 each misalignment
    clean(); chk_valid = 1; act_ch = 6'd5; saddr = 32'h1002; step("R3 sae");
    clean(); chk_valid = 1; act_ch = 6'd6; soff = 16'd1; ssize = 1; step("R3 soe half");
    clean(); chk_valid = 1; act_ch = 6'd7; daddr = 32'h2001; dsize = 1; step("R3 dae");
    clean(); chk_valid = 1; act_ch = 6'd8; doff = 16'd3; step("R3 doe");
    clean(); chk_valid = 1; act_ch = 6'd9; saddr = 32'h3; ssize = 0; daddr = 32'h2; dsize = 1; step("R3 aligned byte/half");
    // R4 R6 group dup keeps channel
    clean(); chk_valid = 1; act_ch = 6'd40; grp_pri = 8'b00_01_10_00; step("R4 R6 gpe");
    // R5 channel dup in group 3
    clean(); chk_valid = 1; act_ch = 6'd41; ch_pri[63*4 +: 4] = 4'd0; step("R5 R6 cpe");
    // R7 cancel
    clean(); cancel = 1; act_ch = 6'd33; step("R7 cancel");
    // R8 ordering: sbe beats misaligned and cancel
    clean(); chk_valid = 1; sbe = 1; dbe = 1; cancel = 1; act_ch = 6'd12; saddr = 32'h1; step("R8 sbe first");
    clean(); dbe = 1; cancel = 1; act_ch = 6'd13; step("R8 dbe over cancel");
    clean(); chk_valid = 1; act_ch = 6'd14; saddr = 32'h1; doff = 16'd2; step("R8 sae over doe");
    // R9 clear, and collision where set wins
    clean(); clr_en = 1; clr_ch = 6'd5; step("R9 clear");
    clean(); sbe = 1; act_ch = 6'd6; clr_en = 1; clr_ch = 6'd6; step("R9 set wins");
    for (int c = 0; c < 64; c++) begin
      clean(); clr_en = 1; clr_ch = 6'(c); step("R2 R9 clear all");
    end

    // random mix
    for (int k = 0; k < 3000; k++) begin
      int rot;
      clean();
      chk_valid = ($urandom % 2) == 0;
      act_ch = 6'($urandom);
      ssize = 2'($urandom); dsize = 2'($urandom);
      saddr = {$urandom} & ~32'h3; daddr = {$urandom} & ~32'h3;
      soff = 16'($urandom) & ~16'h3; doff = 16'($urandom) & ~16'h3;
      if ($urandom % 4 == 0) saddr[1:0] = 2'($urandom);
      if ($urandom % 4 == 0) soff[1:0] = 2'($urandom);
      if ($urandom % 4 == 0) daddr[1:0] = 2'($urandom);
      if ($urandom % 4 == 0) doff[1:0] = 2'($urandom);
      rot = int'($urandom % 4);
      for (int g = 0; g < 4; g++) grp_pri[g*2 +: 2] = 2'((g + rot) % 4);
      for (int c = 0; c < 64; c++) ch_pri[c*4 +: 4] = 4'((c + rot * 3) % 16);
      if ($urandom % 16 == 0) grp_pri[1:0] = grp_pri[3:2];
      if ($urandom % 16 == 0) ch_pri[(16 + $urandom % 16) * 4 +: 4] = ch_pri[16*4 +: 4] ^ 4'd0;
      sbe = ($urandom % 32) == 0;
      dbe = ($urandom % 32) == 0;
      cancel = ($urandom % 16) == 0;
      clr_en = ($urandom % 3) == 0;
      clr_ch = ($urandom % 2 == 0) ? act_ch : 6'($urandom);
      step("R1-R9 random");
    end
    finish_run();
  end
endmodule